// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a serial chain of boundary-scan cells placed around a set of digital input pins and digital output pins. Every cell has a shift stage clocked on the rising test clock and an update latch clocked on the falling test clock. The chain is driven by a test access port controller. That controller provides a select line, which is high when the current instruction routes this chain between the serial input and output. It also provides one-cycle capture, shift and update strobes for the data-register states, and an external-test mode line.

In capture, the stages take a snapshot of the input pins and of the values the functional core wants to drive. In shift, the snapshot moves out toward the serial output while new data enters from the serial input. In update, the output cells' latches take the shifted-in values. When external-test mode is on, those latched values drive the output pins. When it is off, the core's values pass straight through.

Top module: `bscan_chain`

## Requirements
- R1: With `sel` high, a rising `tck` with `capture_en` high loads input cell i with `pin_in[i]`.
- R2: In the same capture, output cell j loads `core_out[j]`.
- R3: The chain order is fixed. Chain position 0, next to `tdi`, is input cell 0. The input cells come first in ascending index, then the output cells in ascending index. `tdo` shows the last output cell. With `sel` and `shift_en` high, each rising `tck` moves every stage one position toward `tdo` and loads `tdi` into position 0.
- R4: With `sel` and `update_en` high, a falling `tck` copies the output cells' shift stages into their update latches.
- R5: The update latches do not change at any edge where update is not active, including throughout shifting.
- R6: With `extest` high, `pad_out` equals the update latches. With `extest` low, `pad_out` equals `core_out`.
- R7: Low `trst_n` asynchronously clears all shift stages and update latches. While it is low, `pad_out` follows `core_out` whatever `extest` is.
- R8: With `sel` low, the capture, shift and update strobes have no effect, and the shift stages keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial data into chain position 0 |
| sel | input | 1 | Chain selected by the current instruction |
| capture_en | input | 1 | Capture-DR strobe |
| shift_en | input | 1 | Shift-DR strobe |
| update_en | input | 1 | Update-DR strobe |
| extest | input | 1 | External-test mode: latches drive the pads |
| pin_in | input | N_IN | Digital input pin values |
| core_out | input | N_OUT | Functional core values for the output pins |
| pad_out | output | N_OUT | Values driven to the output pins |
| tdo | output | 1 | Serial output from the last chain position |

## Verification
A wrong shift-stage value stays hidden until the next shift. It then appears on `tdo` in the cycle whose position matches the faulty cell, which is at most N_IN+N_OUT rising edges after capture. A wrong update latch shows on `pad_out` immediately under external-test mode and never in functional mode. For that reason, every update is followed by a pad check with `extest` high. Mis-ordered cells produce a `tdo` sequence that comes out permuted.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             sel,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             extest,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pad_out,
  output logic             tdo
);
  localparam int LEN = N_IN + N_OUT;

  logic [LEN-1:0]   stg;
  logic [N_OUT-1:0] upd;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)
      stg <= '0;
    else if (sel && capture_en)
      stg <= {core_out, pin_in};
    else if (sel && shift_en)
      stg <= {stg[LEN-2:0], tdi};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)
      upd <= '0;
    else if (sel && update_en)
      upd <= stg[LEN-1:N_IN];
  end

  assign pad_out = (extest && trst_n) ? upd : core_out;
  assign tdo     = stg[LEN-1];

  // R1
  cap_in_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && capture_en) |=> stg[N_IN-1:0] == $past(pin_in));

  // R3
  shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && shift_en && !capture_en) |=> tdo == $past(stg[LEN-2]));

  // R5
  upd_hold_chk: assert property (@(negedge tck) disable iff (!trst_n)
    !(sel && update_en) |=> $stable(upd));

  // R8
  unsel_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |=> $stable(stg));
endmodule

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int L  = NI + NO;

  logic tck = 0, trst_n = 0, tdi = 0, sel = 0;
  logic capture_en = 0, shift_en = 0, update_en = 0, extest = 0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0;
  logic [NO-1:0] pad_out;
  logic tdo;
  int checks = 0, errors = 0;

  always #4 tck = ~tck;

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) u0 (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .sel(sel),
    .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
    .extest(extest), .pin_in(pin_in), .core_out(core_out),
    .pad_out(pad_out), .tdo(tdo));

  // {pin_in[3:0], core_out[2:0], shift-in word[6:0], extest}
  localparam logic [14:0] VEC [4] = '{
    {4'b1010, 3'b011, 7'b1100101, 1'b1},
    {4'b0110, 3'b101, 7'b0011010, 1'b1},
    {4'b1111, 3'b000, 7'b1010111, 1'b0},
    {4'b0001, 3'b110, 7'b0101000, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_edge();
    @(posedge tck); #1;
  endtask

  // capture, shift out/in, update; checks tdo sequence and pad hold during shift
  task automatic scan(logic [L-1:0] w, logic [L-1:0] expcap, logic do_cap, string req);
    logic [NO-1:0] pad0;
    drive_edge();
    capture_en = do_cap;
    drive_edge();
    capture_en = 0;
    pad0 = pad_out;
    for (int k = 0; k < L; k++) begin
      shift_en = 1;
      tdi = w[L-1-k];
      #6;
      check(req, tdo, expcap[L-1-k]);
      check("R5", pad_out, pad0);
      drive_edge();
    end
    shift_en = 0;
    update_en = 1;
    drive_edge();
    update_en = 0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7: in reset, pads follow core even with extest high
    extest = 1; core_out = 3'b101;
    #13;
    check("R7", pad_out, 3'b101);
    trst_n = 1;
    drive_edge(); #6;
    check("R7", pad_out, 3'b000);
    check("R7", tdo, 1'b0);

    sel = 1;
    foreach (VEC[i]) begin
      logic [NI-1:0] p; logic [NO-1:0] c; logic [L-1:0] w; logic e;
      {p, c, w, e} = VEC[i];
      pin_in = p; core_out = c; extest = e;
      // R1 R2 R3: captured {core_out, pin_in} leaves tdo MSB first
      scan(w, {c, p}, 1'b1, "R3");
      #6;
      // R4 R6
      check("R6", pad_out, e ? w[L-1:NI] : c);
      extest = 1; #1;
      check("R4", pad_out, w[L-1:NI]);
    end

    // R6: functional mode passes core_out
    extest = 0; core_out = 3'b010; #1;
    check("R6", pad_out, 3'b010);

    // R8: strobes with sel low are ignored
    extest = 1;
    pin_in = 4'b1001; core_out = 3'b111;
    drive_edge();
    sel = 1; capture_en = 1;
    drive_edge();
    capture_en = 0; sel = 0;
    capture_en = 1; pin_in = 4'b0000; core_out = 3'b000;
    drive_edge();
    capture_en = 0; shift_en = 1; tdi = 0;
    drive_edge(); drive_edge();
    shift_en = 0; update_en = 1;
    drive_edge();
    update_en = 0; #6;
    check("R8", pad_out, VEC[3][7:5]);
    sel = 1;
    scan(7'b0000000, {3'b111, 4'b1001}, 1'b0, "R8");
    #6;
    check("R4", pad_out, 3'b000);

    // R7: async reset mid-operation clears latches
    scan(7'b1110000, {3'b000, 4'b0000}, 1'b0, "R3");
    #6;
    check("R4", pad_out, 3'b111);
    #1 trst_n = 0; #1;
    check("R7", pad_out, core_out);
    trst_n = 1; #1;
    check("R7", pad_out, 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule